// File: doc/BRIEF.md
# Buffered SPI Master Transmitter

This block is the transmit half of an SPI master. A single holding register sits in front of the shift register, so software can queue the next character while the current one is still being clocked out, and consecutive characters leave with no idle time between them. The serial clock is derived from the system clock by a programmable divider. It idles low. Data is placed on the output when the clock falls, and the receiver samples it on the rising edge. Character length runs from 1 to 16 bits, and either bit order can be selected.

Two status flags report progress. The holding-empty flag rises when the queued word moves into the shift register. The transfer-done flag rises when the last clock of a character has completed and nothing is waiting. Each flag has its own interrupt enable. Slave select is handled elsewhere by software.

The data input uses a valid/ready handshake with no back-pressure: `tx_ready` is always high, and every cycle with `tx_valid` high is a write. A write made while a word is already waiting replaces that word. Software avoids this by writing only when the holding-empty flag is set.

Top module: `spi_tx_master`

## Requirements
- R1: After reset, `sclk`, `sdo`, `busy`, `flag_end`, `irq_end` are 0, `flag_empty` is 1 and `tx_ready` is 1.
- R2: When the engine is idle, a word written in cycle n is moved into the shift register at the end of cycle n+1. From then on `busy` and `flag_empty` read 1.
- R3: Every write drops `flag_empty` to 0 on the next cycle. A write made while a word is already waiting replaces that word and adds no extra character.
- R4: Each character produces exactly `cfg_chlen`+1 clock pulses. Each high and each low phase lasts `cfg_div`+1 system clocks. `sclk` is 0 whenever `busy` is 0.
- R5: `sdo` changes only at a falling `sclk` edge or at a load, and it holds steady while `sclk` is high. With `cfg_lsb_first`=0, bit index `cfg_chlen` is sent first and bit 0 last. With `cfg_lsb_first`=1, bit 0 is sent first. Bits above `cfg_chlen` are never sent. `sdo` is 0 when idle.
- R6: A word that is waiting when the last falling edge of a character occurs is loaded on that same edge. The next low phase begins at once, and `busy` does not drop between the two characters.
- R7: If nothing is waiting at the last falling edge, the clock stops, `busy` drops and `flag_end` is set, all on that edge.
- R8: `irq_empty` equals `flag_empty` AND `ie_empty`, and `irq_end` equals `flag_end` AND `ie_end`, in the same cycle.
- R9: A cycle with `end_clr`=1 clears `flag_end`. When a set and a clear happen on the same edge, the set wins.
- R10: Length and bit order are captured when a word is loaded. Changing them during a character affects only later characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Clock half-period minus one, in system clocks |
| cfg_chlen | input | $clog2(DW) | Character length minus one |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| ie_empty | input | 1 | Holding-empty interrupt enable |
| ie_end | input | 1 | Transfer-done interrupt enable |
| tx_valid | input | 1 | Write strobe for the holding register |
| tx_data | input | DW | Word to send |
| tx_ready | output | 1 | Always 1; writes are never stalled |
| end_clr | input | 1 | Clears the transfer-done flag |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| busy | output | 1 | A character is being shifted |
| flag_empty | output | 1 | Holding register is free |
| flag_end | output | 1 | Transfer has stopped |
| irq_empty | output | 1 | Holding-empty interrupt request |
| irq_end | output | 1 | Transfer-done interrupt request |

## Verification
The hardest case to reach is a write that lands exactly on the final falling edge of a character. One cycle earlier, the write would be chained with no gap. One cycle later, it would restart the engine from idle after the done flag has set. The bench sweeps the delay between the holding-empty flag and the second write across every cycle of a short 3-bit character at the fastest divider, so one pass of the sweep hits that edge. In some sweep passes it also holds the clear input high, so that a set and a clear of the done flag coincide.

// File: rtl/spi_tx_pkg.sv
package spi_tx_pkg;
  typedef enum logic {
    ORDER_MSB = 1'b0,
    ORDER_LSB = 1'b1
  } bit_order_e;
endpackage

// File: rtl/spi_tx_holdbuf.sv
module spi_tx_holdbuf #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] word,
  output logic          empty_flag
);
  // A write always wins over a take on the same edge: the taken word is the old one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full       <= 1'b0;
      word       <= '0;
      empty_flag <= 1'b1;
    end else begin
      if (wr_en) begin
        word       <= wr_data;
        full       <= 1'b1;
        empty_flag <= 1'b0;
      end else if (take) begin
        full       <= 1'b0;
        empty_flag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_tx_clkgen.sv
module spi_tx_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick      = run && (cnt == div);
  assign fall_tick = tick && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (tick) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter
  import spi_tx_pkg::*;
#(
  parameter int DW  = 16,
  localparam int CLW = $clog2(DW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [DW-1:0]  load_data,
  input  logic [CLW-1:0] chlen,
  input  bit_order_e     order,
  input  logic           fall_tick,
  output logic           active,
  output logic           last,
  output logic           sdo
);
  localparam logic [CLW-1:0] TOP_IDX = CLW'(DW - 1);

  logic [DW-1:0]  shreg;
  logic [CLW-1:0] bits_left;
  bit_order_e     order_q;
  logic [CLW-1:0] align;

  // MSB-first words are left-aligned so the first bit sits at the top.
  assign align = TOP_IDX - chlen;
  assign last  = (bits_left == '0);
  assign sdo   = active && ((order_q == ORDER_LSB) ? shreg[0] : shreg[DW-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      shreg     <= '0;
      bits_left <= '0;
      order_q   <= ORDER_MSB;
    end else if (load) begin
      active    <= 1'b1;
      bits_left <= chlen;
      order_q   <= order;
      shreg     <= (order == ORDER_LSB) ? load_data : (load_data << align);
    end else if (active && fall_tick) begin
      if (last) begin
        active <= 1'b0;
      end else begin
        bits_left <= bits_left - 1'b1;
        shreg     <= (order_q == ORDER_LSB) ? {1'b0, shreg[DW-1:1]}
                                            : {shreg[DW-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_tx_flags.sv
module spi_tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_end,
  input  logic clr_end,
  input  logic empty_flag,
  input  logic ie_empty,
  input  logic ie_end,
  output logic flag_end,
  output logic irq_empty,
  output logic irq_end
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_end <= 1'b0;
    else if (set_end) flag_end <= 1'b1;
    else if (clr_end) flag_end <= 1'b0;
  end

  assign irq_empty = empty_flag && ie_empty;
  assign irq_end   = flag_end && ie_end;
endmodule

// File: rtl/spi_tx_master.sv
module spi_tx_master
  import spi_tx_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DIV_W = 8,
  localparam int CLW  = $clog2(DW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [CLW-1:0]   cfg_chlen,
  input  logic             cfg_lsb_first,
  input  logic             ie_empty,
  input  logic             ie_end,
  input  logic             tx_valid,
  input  logic [DW-1:0]    tx_data,
  output logic             tx_ready,
  input  logic             end_clr,
  output logic             sclk,
  output logic             sdo,
  output logic             busy,
  output logic             flag_empty,
  output logic             flag_end,
  output logic             irq_empty,
  output logic             irq_end
);
  logic          buf_full;
  logic [DW-1:0] buf_word;
  logic          fall_tick;
  logic          last_bit;
  logic          load;
  logic          done;

  assign tx_ready = 1'b1;
  // Load from idle, or chain on the final falling edge of the current character.
  assign load = buf_full && (!busy || (fall_tick && last_bit));
  assign done = busy && fall_tick && last_bit && !buf_full;

  spi_tx_holdbuf #(.DW(DW)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (tx_valid),
    .wr_data    (tx_data),
    .take       (load),
    .full       (buf_full),
    .word       (buf_word),
    .empty_flag (flag_empty)
  );

  spi_tx_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .div       (cfg_div),
    .sclk      (sclk),
    .fall_tick (fall_tick)
  );

  spi_tx_shifter #(.DW(DW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_data (buf_word),
    .chlen     (cfg_chlen),
    .order     (bit_order_e'(cfg_lsb_first)),
    .fall_tick (fall_tick),
    .active    (busy),
    .last      (last_bit),
    .sdo       (sdo)
  );

  spi_tx_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_end    (done),
    .clr_end    (end_clr),
    .empty_flag (flag_empty),
    .ie_empty   (ie_empty),
    .ie_end     (ie_end),
    .flag_end   (flag_end),
    .irq_empty  (irq_empty),
    .irq_end    (irq_end)
  );
endmodule

// File: rtl/spi_tx_master_chk.sv
module spi_tx_master_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic end_clr,
  input logic busy,
  input logic sclk,
  input logic sdo,
  input logic flag_empty,
  input logic flag_end,
  input logic irq_end
);
  // R4: the clock rests low outside a character
  a_r4_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  // R5: data never moves while the clock is high
  a_r5_sdo_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdo));

  // R3: any write empties nothing and drops the empty flag
  a_r3_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> !flag_empty);

  // R2: the empty flag only rises when a word enters the shifter
  a_r2_empty_on_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_empty) |-> busy);

  // R7: done flag rises only together with the clock stopping
  a_r7_end_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_end) |-> (!busy && !sclk));

  // R9: a clear with no transfer running leaves the flag low
  a_r9_clear_end: assert property (@(posedge clk) disable iff (!rst_n)
    (end_clr && !busy) |=> !flag_end);

  // R8: the done request never appears without its flag
  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_end |-> flag_end);
endmodule

bind spi_tx_master spi_tx_master_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_valid   (tx_valid),
  .end_clr    (end_clr),
  .busy       (busy),
  .sclk       (sclk),
  .sdo        (sdo),
  .flag_empty (flag_empty),
  .flag_end   (flag_end),
  .irq_end    (irq_end)
);

// File: tb/spi_tx_master_tb.sv
`timescale 1ns/1ps
module spi_tx_master_tb;
  localparam int DW = 16;
  localparam int DIV_W = 8;
  localparam int CLW = $clog2(DW);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] cfg_div = '0;
  logic [CLW-1:0]   cfg_chlen = 4'd7;
  logic             cfg_lsb_first = 1'b0;
  logic             ie_empty = 1'b1;
  logic             ie_end = 1'b1;
  logic             tx_valid = 1'b0;
  logic [DW-1:0]    tx_data = '0;
  logic             tx_ready;
  logic             end_clr = 1'b0;
  logic             sclk, sdo, busy, flag_empty, flag_end, irq_empty, irq_end;

  always #10 clk = ~clk;

  spi_tx_master #(.DW(DW), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_chlen(cfg_chlen),
    .cfg_lsb_first(cfg_lsb_first), .ie_empty(ie_empty), .ie_end(ie_end),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .end_clr(end_clr), .sclk(sclk), .sdo(sdo), .busy(busy),
    .flag_empty(flag_empty), .flag_end(flag_end),
    .irq_empty(irq_empty), .irq_end(irq_end)
  );

  int n_chk = 0;
  int n_err = 0;
  bit cmp_on = 0;

  task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  // Behavioural reference: a queue of pending bits and a phase counter.
  bit          m_busy, m_sclk, m_bfull, m_empty, m_end;
  int          m_phase;
  logic [DW-1:0] m_word;
  bit          m_q[$];

  task automatic m_start();
    int n;
    n = int'(cfg_chlen);
    m_q.delete();
    for (int i = 0; i <= n; i++)
      m_q.push_back(m_word[cfg_lsb_first ? i : n - i]);
    m_bfull = 0; m_empty = 1; m_busy = 1; m_phase = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_sclk = 0; m_bfull = 0; m_empty = 1; m_end = 0;
      m_phase = 0; m_word = '0; m_q.delete();
    end else begin
      if (end_clr) m_end = 0;
      if (m_busy) begin
        m_phase++;
        if (m_phase == int'(cfg_div) + 1) begin
          m_phase = 0;
          if (!m_sclk) m_sclk = 1;
          else begin
            m_sclk = 0;
            void'(m_q.pop_front());
            if (m_q.size() == 0) begin
              if (m_bfull) m_start();
              else begin m_busy = 0; m_end = 1; end
            end
          end
        end
      end else if (m_bfull) m_start();
      if (tx_valid) begin m_word = tx_data; m_bfull = 1; m_empty = 0; end
    end
  end

  // Event counters for directed checks
  int rises = 0, busy_falls = 0;
  logic prev_sclk = 0, prev_busy = 0;

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      check("R4", "sclk", sclk, m_sclk);
      check("R5 R10", "sdo", sdo, (m_busy && m_q.size() > 0) ? m_q[0] : 1'b0);
      check("R6 R7", "busy", busy, m_busy);
      check("R3", "flag_empty", flag_empty, m_empty);
      check("R7 R9", "flag_end", flag_end, m_end);
      check("R8", "irq_empty", irq_empty, m_empty & ie_empty);
      check("R8", "irq_end", irq_end, m_end & ie_end);
      check("R3", "tx_ready", tx_ready, 1'b1);
      if (sclk && !prev_sclk) rises++;
      if (!busy && prev_busy) busy_falls++;
    end
    prev_sclk = sclk;
    prev_busy = busy;
  end

  task automatic send(logic [DW-1:0] w);
    @(negedge clk); tx_valid = 1'b1; tx_data = w;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_busy || m_bfull);
  endtask

  task automatic wait_empty();
    do @(negedge clk); while (!m_empty);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "sclk", sclk, 0);
    check("R1", "sdo", sdo, 0);
    check("R1", "busy", busy, 0);
    check("R1", "flag_empty", flag_empty, 1);
    check("R1", "flag_end", flag_end, 0);
    check("R1", "irq_end", irq_end, 0);
    check("R1", "tx_ready", tx_ready, 1);
    cmp_on = 1;

    // R2 timing from idle, then R4 pulse count and R7/R9 flag handling
    rises = 0;
    @(negedge clk); tx_valid = 1'b1; tx_data = 16'h00A5;
    @(negedge clk); tx_valid = 1'b0;
    check("R2", "busy one cycle after write", busy, 0);
    check("R2", "flag_empty after write", flag_empty, 0);
    @(negedge clk);
    check("R2", "busy after transfer", busy, 1);
    check("R2", "flag_empty after transfer", flag_empty, 1);
    wait_idle();
    @(negedge clk);
    check("R4", "pulses for 8-bit char", rises, 8);
    check("R7", "flag_end after stop", flag_end, 1);
    check("R8", "irq_end after stop", irq_end, 1);
    @(negedge clk); end_clr = 1'b1;
    @(negedge clk); end_clr = 1'b0;
    check("R9", "flag_end after clear", flag_end, 0);

    // R6 back-to-back characters
    cfg_div = 8'd1; busy_falls = 0; rises = 0;
    send(16'h003C);
    wait_empty();
    send(16'h00C3);
    wait_idle();
    @(negedge clk);
    check("R6", "busy drops once over two chars", busy_falls, 1);
    check("R6", "pulses over two chars", rises, 16);

    // R3 overwrite of a waiting word
    cfg_div = 8'd2; cfg_chlen = 4'd15; rises = 0; ie_empty = 1'b0;
    send(16'h1234);
    wait_empty();
    send(16'hAAAA);
    send(16'h5555);
    wait_idle();
    @(negedge clk);
    check("R3", "overwrite adds no char", rises, 32);

    // R5 bit order, 1-bit and 5-bit characters with masked upper bits
    ie_empty = 1'b1; ie_end = 1'b0;
    cfg_div = 8'd0; cfg_lsb_first = 1'b1; cfg_chlen = 4'd0;
    send(16'h0001); wait_idle();
    send(16'hFFFE); wait_idle();
    cfg_chlen = 4'd4;
    send(16'hFFF3); wait_idle();
    cfg_lsb_first = 1'b0;
    send(16'hFFEA); wait_idle();

    // R10 configuration change during a character
    ie_end = 1'b1; cfg_div = 8'd1; cfg_chlen = 4'd15; rises = 0;
    send(16'hF00F);
    repeat (5) @(negedge clk);
    cfg_chlen = 4'd3; cfg_lsb_first = 1'b1;
    wait_idle();
    @(negedge clk);
    check("R10", "length held during char", rises, 16);

    // Sweep write timing around the final edge; some passes hold the clear
    cfg_div = 8'd0; cfg_chlen = 4'd2; cfg_lsb_first = 1'b0;
    for (int d = 0; d < 10; d++) begin
      end_clr = (d % 3 == 0);
      send(16'(d * 5 + 1));
      wait_empty();
      repeat (d) @(negedge clk);
      send(~16'(d));
      wait_idle();
      end_clr = 1'b0;
      repeat (2) @(negedge clk);
    end

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule